// File: doc/BRIEF.md
# Configurable Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial audio port. Parallel 32-bit words are written into a small transmit queue. At each word boundary the head of the queue is taken into a word register, and one field of that word is sent onto a single data pin, one bit per bit-clock period. A frame-sync output marks where each word begins. Word length, bit order, field alignment, the bit-clock edge that launches data, and the frame-sync polarity, length and timing are all chosen by static configuration inputs. These inputs are changed only while the transmitter is disabled.

The bit clock and the frame sync can each be made by the block or taken from an outside source. With both made internally, the bit clock runs at half the system clock rate. Frames follow one another with no idle bit clocks between them. A single lead slot comes first after enable and carries zero data. With an external frame sync, a frame starts on the launch edge where the sync first becomes active. The block raises a flag when the queue can take another word, and it can route that flag to an interrupt output. If a word boundary arrives while the queue is empty, the block sends a zero word and sets a sticky underrun flag.

Top module: `sstx_top`

## Requirements
- R1: `wlSel` picks the word length: 0→8, 1→10, 2→12, 3→16, 4→18, 5→20, 6→22, 7→24 bits. With an internal frame sync, the first launch edge after enable is a lead slot with data 0. Each later run of word-length launch edges is one frame, and frames follow with no gap.
- R2: `lsbFirst`=0 sends the selected field from its top bit down to its bottom bit. `lsbFirst`=1 sends it from the bottom bit up.
- R3: `alignLsb`=1 selects bits [WL-1:0] of the written word. `alignLsb`=0 selects a field whose top bit is 31 when WL is 16 or more, and 15 when WL is 8, 10 or 12.
- R4: `launchFalling`=0 changes `txData` and `fsOut` on the rising edge of the bit clock. `launchFalling`=1 changes them on the falling edge.
- R5: `fsInvert`=0 makes `fsOut` active high and `fsIn` active high. `fsInvert`=1 makes both active low. Outside a sync pulse, `fsOut` sits at its inactive level.
- R6: `fsBitLong`=1 makes the internal sync active for one slot. `fsBitLong`=0 keeps it active for whole words, so with back-to-back frames it stays active from its first slot on.
- R7: `fsEarly`=0 starts the internal sync in the slot of the first data bit. `fsEarly`=1 starts it one slot earlier, which is the lead slot or the last bit of the previous word. With an external sync and `fsEarly`=1, the first data bit goes out one launch edge after the sync is seen.
- R8: With `fifoEnable`=1 the queue holds 8 words, and a write to a full queue is dropped. `txDataEmpty` is 1 exactly when the queue holds fewer than 8 words, so 8 queued words plus 1 in transmission keep it at 0.
- R9: With `fifoEnable`=0 a single word is held, and a second write is dropped. `txDataEmpty` goes back to 1 once that word moves into transmission.
- R10: A word boundary with an empty queue sends an all-zero word and sets `txUnderrun`. The flag stays set until `underrunClr` is pulsed.
- R11: `txIrq` is `txDataEmpty` AND `irqEnable`.
- R12: With `clkInternal`=0 and `fsInternal`=0, launch edges come from `bitClkIn` and frames start from `fsIn`. After the last bit of a frame, `txData` is 0 until the next sync, and `bitClkOutEn` and `fsOutEn` are 0.
- R13: After reset, `txData`=0, `bitClkOut`=0, `txUnderrun`=0, `txDataEmpty`=1, and `fsOut` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Runs the serializer; low returns it to the pre-start state |
| wlSel | input | 3 | Word length code |
| lsbFirst | input | 1 | Bit order select |
| alignLsb | input | 1 | Field alignment select |
| launchFalling | input | 1 | Bit-clock launch edge select |
| fsInvert | input | 1 | Frame-sync active-low select |
| fsBitLong | input | 1 | One-slot sync when 1, word-long when 0 |
| fsEarly | input | 1 | Sync one slot before data when 1 |
| fifoEnable | input | 1 | 8-deep queue when 1, single holding word when 0 |
| clkInternal | input | 1 | Bit clock made by the block when 1 |
| fsInternal | input | 1 | Frame sync made by the block when 1 |
| bitClkIn | input | 1 | External bit clock, synchronous to clk |
| fsIn | input | 1 | External frame sync |
| wrValid | input | 1 | Write strobe for one word |
| wrData | input | 32 | Word to transmit |
| irqEnable | input | 1 | Interrupt enable |
| underrunClr | input | 1 | Clears the underrun flag |
| bitClkOut | output | 1 | Internally made bit clock |
| bitClkOutEn | output | 1 | Drive enable for the bit-clock pin |
| fsOut | output | 1 | Internally made frame sync |
| fsOutEn | output | 1 | Drive enable for the frame-sync pin |
| txData | output | 1 | Serial data |
| txDataEmpty | output | 1 | Queue can take another word |
| txUnderrun | output | 1 | Sticky underrun flag |
| txIrq | output | 1 | Interrupt request |

## Verification
The assertions rely on several facts about the inputs. The configuration inputs are held steady while `txEnable` is high. `bitClkIn` changes no faster than once per two system clocks. `fifoEnable` changes only while the queue is empty. The bench keeps to all of these. It loads words and changes configuration only at the falling edge of the clock while the transmitter is disabled. It drives the external bit clock with a full system-clock cycle in each phase. It drains the queue before every configuration change. The scoreboard predicts every launched bit and sync level from the requirement rules alone.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  localparam int WORD_W = 32;
  localparam int SLOT_W = $clog2(WORD_W);

  typedef struct packed {
    logic              tick;    // launch edge this cycle
    logic              load;    // word boundary: take next word
    logic              active;  // next slot carries frame data
    logic [SLOT_W-1:0] slot;    // index of next slot within the word
  } txStrobe_t;

  function automatic logic [SLOT_W-1:0] wordLen(input logic [2:0] sel);
    case (sel)
      3'd0: wordLen = SLOT_W'(8);
      3'd1: wordLen = SLOT_W'(10);
      3'd2: wordLen = SLOT_W'(12);
      3'd3: wordLen = SLOT_W'(16);
      3'd4: wordLen = SLOT_W'(18);
      3'd5: wordLen = SLOT_W'(20);
      3'd6: wordLen = SLOT_W'(22);
      default: wordLen = SLOT_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/sstx_ctrl.sv
module sstx_ctrl
  import sstx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic [2:0] wlSel,
  input  logic      launchFalling,
  input  logic      fsInvert,
  input  logic      fsBitLong,
  input  logic      fsEarly,
  input  logic      clkInternal,
  input  logic      fsInternal,
  input  logic      bitClkIn,
  input  logic      fsIn,
  output txStrobe_t strb,
  output logic      bitClkOut,
  output logic      fsOut
);
  logic [SLOT_W-1:0] wl, lastSlot, slotQ, slotN;
  logic bclkQ, extPrevQ, actPrevQ, pendQ, activeQ, fsQ;
  logic tick, fsAct, actRise, startNow, activeN, fsLvl;

  assign wl       = wordLen(wlSel);
  assign lastSlot = wl - SLOT_W'(1);

  // launch edge: internal clock runs at clk/2, external is edge-detected
  assign tick = txEnable & (clkInternal ? (bclkQ == launchFalling)
                                        : ((bitClkIn != extPrevQ) && (bitClkIn == !launchFalling)));

  assign fsAct   = fsIn ^ fsInvert;
  assign actRise = fsAct & !actPrevQ;

  always_comb begin
    if (fsInternal)  startNow = (slotQ == lastSlot);
    else if (fsEarly) startNow = pendQ;
    else             startNow = actRise;
    slotN   = startNow ? '0 : ((slotQ == lastSlot) ? lastSlot : slotQ + SLOT_W'(1));
    activeN = startNow | (activeQ & (slotQ != lastSlot));
    if (!fsInternal)  fsLvl = 1'b0;
    else if (fsEarly) fsLvl = fsBitLong ? (slotN == lastSlot) : ((slotN == lastSlot) | activeN);
    else              fsLvl = fsBitLong ? startNow : activeN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ    <= 1'b0;
      extPrevQ <= 1'b0;
      actPrevQ <= 1'b0;
      pendQ    <= 1'b0;
      activeQ  <= 1'b0;
      fsQ      <= 1'b0;
      slotQ    <= '0;
    end else begin
      extPrevQ <= bitClkIn;
      if (!txEnable) begin
        bclkQ    <= 1'b0;
        actPrevQ <= 1'b0;
        pendQ    <= 1'b0;
        activeQ  <= 1'b0;
        fsQ      <= 1'b0;
        slotQ    <= fsInternal ? (wl - SLOT_W'(2)) : lastSlot;
      end else begin
        if (clkInternal) bclkQ <= ~bclkQ;
        if (tick) begin
          slotQ    <= slotN;
          activeQ  <= activeN;
          actPrevQ <= fsAct;
          pendQ    <= !fsInternal & fsEarly & actRise;
          fsQ      <= fsLvl;
        end
      end
    end
  end

  assign bitClkOut   = bclkQ;
  assign fsOut       = fsQ ^ fsInvert;
  assign strb.tick   = tick;
  assign strb.load   = tick & startNow;
  assign strb.active = activeN;
  assign strb.slot   = slotN;

  // R4: an internal launch tick lands the bit clock on the chosen edge level
  p_launch_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && clkInternal) |=> (bitClkOut == !launchFalling));

  // R1: the slot counter never leaves the word
  p_slot_in_word_r1: assert property (@(posedge clk) disable iff (!rstN)
    txEnable |-> (slotQ <= lastSlot));

  // R7: an early external sync always delays the start by one tick
  p_early_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !fsInternal && fsEarly && actRise) |=> pendQ);
endmodule

// File: rtl/sstx_dp.sv
module sstx_dp
  import sstx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  txStrobe_t         strb,
  input  logic [2:0]        wlSel,
  input  logic              lsbFirst,
  input  logic              alignLsb,
  input  logic              fifoEnable,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  input  logic              irqEnable,
  input  logic              underrunClr,
  output logic              txData,
  output logic              txDataEmpty,
  output logic              txUnderrun,
  output logic              txIrq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [SLOT_W-1:0] HI_TOP = SLOT_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] LO_TOP = SLOT_W'(WORD_W / 2 - 1);
  localparam logic [SLOT_W-1:0] WIDE_MIN = SLOT_W'(WORD_W / 2);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count, cap;
  logic              push, pop;
  logic [WORD_W-1:0] wordQ, wordN, loadVal;
  logic [SLOT_W-1:0] wl, top, bot, idx;
  logic              dataQ, underrunQ;

  assign cap  = fifoEnable ? CNT_W'(DEPTH) : CNT_W'(1);
  assign push = wrValid && (count < cap);
  assign pop  = strb.load && (count != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= wrData;
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      end
      if (pop) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // field selection and bit order
  always_comb begin
    wl      = wordLen(wlSel);
    top     = alignLsb ? (wl - SLOT_W'(1)) : ((wl >= WIDE_MIN) ? HI_TOP : LO_TOP);
    bot     = top - wl + SLOT_W'(1);
    idx     = lsbFirst ? (bot + strb.slot) : (top - strb.slot);
    loadVal = (count != '0) ? mem[rdPtr] : '0;
    wordN   = strb.load ? loadVal : wordQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ     <= '0;
      dataQ     <= 1'b0;
      underrunQ <= 1'b0;
    end else begin
      if (!txEnable) dataQ <= 1'b0;
      else if (strb.tick) begin
        wordQ <= wordN;
        dataQ <= strb.active ? wordN[idx] : 1'b0;
      end
      if (strb.load && count == '0) underrunQ <= 1'b1;
      else if (underrunClr)         underrunQ <= 1'b0;
    end
  end

  assign txData      = dataQ;
  assign txUnderrun  = underrunQ;
  assign txDataEmpty = count < cap;
  assign txIrq       = txDataEmpty & irqEnable;

  // R8: occupancy never exceeds the queue depth
  p_fifo_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R8: a write to a full queue leaves it unchanged when nothing leaves
  p_full_write_dropped_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && count >= cap && !pop) |=> (count == $past(count)));

  // R10: underrun holds until cleared
  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txUnderrun && !underrunClr) |=> txUnderrun);

  // R8/R9: the room flag only drops after a write
  p_flag_falls_on_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDataEmpty) |-> $past(wrValid));
endmodule

// File: rtl/sstx_top.sv
module sstx_top
  import sstx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txEnable,
  input  logic [2:0]  wlSel,
  input  logic        lsbFirst,
  input  logic        alignLsb,
  input  logic        launchFalling,
  input  logic        fsInvert,
  input  logic        fsBitLong,
  input  logic        fsEarly,
  input  logic        fifoEnable,
  input  logic        clkInternal,
  input  logic        fsInternal,
  input  logic        bitClkIn,
  input  logic        fsIn,
  input  logic        wrValid,
  input  logic [31:0] wrData,
  input  logic        irqEnable,
  input  logic        underrunClr,
  output logic        bitClkOut,
  output logic        bitClkOutEn,
  output logic        fsOut,
  output logic        fsOutEn,
  output logic        txData,
  output logic        txDataEmpty,
  output logic        txUnderrun,
  output logic        txIrq
);
  txStrobe_t strb;

  sstx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wlSel(wlSel),
    .launchFalling(launchFalling), .fsInvert(fsInvert), .fsBitLong(fsBitLong),
    .fsEarly(fsEarly), .clkInternal(clkInternal), .fsInternal(fsInternal),
    .bitClkIn(bitClkIn), .fsIn(fsIn), .strb(strb),
    .bitClkOut(bitClkOut), .fsOut(fsOut)
  );

  sstx_dp #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .strb(strb), .wlSel(wlSel),
    .lsbFirst(lsbFirst), .alignLsb(alignLsb), .fifoEnable(fifoEnable),
    .wrValid(wrValid), .wrData(wrData), .irqEnable(irqEnable),
    .underrunClr(underrunClr), .txData(txData), .txDataEmpty(txDataEmpty),
    .txUnderrun(txUnderrun), .txIrq(txIrq)
  );

  assign bitClkOutEn = clkInternal;
  assign fsOutEn     = fsInternal;
endmodule

// File: tb/sstx_top_bench.sv
module sstx_top_bench;
  logic clk = 1'b0, rstN = 1'b0, txEnable = 1'b0;
  logic [2:0] wlSel = 3'd0;
  logic lsbFirst = 0, alignLsb = 0, launchFalling = 0, fsInvert = 0;
  logic fsBitLong = 1, fsEarly = 0, fifoEnable = 1, clkInternal = 1, fsInternal = 1;
  logic bitClkIn = 0, fsIn = 0, wrValid = 0, irqEnable = 0, underrunClr = 0;
  logic [31:0] wrData = '0;
  logic bitClkOut, bitClkOutEn, fsOut, fsOutEn, txData, txDataEmpty, txUnderrun, txIrq;

  int nChecks = 0, nFails = 0;
  logic [1:0] expQ[$];
  string tagQ[$];
  logic prevClk = 1'b0;
  int wlTab[8] = '{8, 10, 12, 16, 18, 20, 22, 24};

  always #5 clk = ~clk;

  sstx_top u_sstx_top (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each launched bit and sync level in internal-clock mode
  always @(negedge clk) begin
    if (bitClkOut !== prevClk && bitClkOut === !launchFalling && expQ.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk({t, " data"}, {31'd0, txData}, {31'd0, e[1]});
      chk({t, " sync"}, {31'd0, fsOut},  {31'd0, e[0]});
    end
    prevClk = bitClkOut;
  end

  function automatic logic expBit(logic [31:0] w, int j);
    int wl, top, bot;
    wl  = wlTab[wlSel];
    top = alignLsb ? wl - 1 : (wl >= 16 ? 31 : 15);   // R3
    bot = top - wl + 1;
    return lsbFirst ? w[bot + j] : w[top - j];        // R2
  endfunction

  function automatic logic expFs(bit lead, int j);
    int wl;
    logic lvl;
    wl = wlTab[wlSel];
    if (lead) lvl = fsEarly;                                   // R7
    else if (fsEarly) lvl = fsBitLong ? (j == wl - 1) : 1'b1;  // R6 R7
    else lvl = fsBitLong ? (j == 0) : 1'b1;
    return lvl ^ fsInvert;                                     // R5
  endfunction

  task automatic cfg(int w, bit lf, bit al, bit fall, bit inv, bit bl, bit er, bit fe);
    @(negedge clk);
    wlSel = 3'(w); lsbFirst = lf; alignLsb = al; launchFalling = fall;
    fsInvert = inv; fsBitLong = bl; fsEarly = er; fifoEnable = fe;
    @(negedge clk);
  endtask

  task automatic writeWord(logic [31:0] w);
    @(negedge clk); wrValid = 1; wrData = w;
    @(negedge clk); wrValid = 0;
  endtask

  task automatic clearUnderrun();
    @(negedge clk); underrunClr = 1;
    @(negedge clk); underrunClr = 0;
  endtask

  // driver: predicts the lead slot, the data frames and the underrun frames
  task automatic runInternal(string tag, logic [31:0] words[$], int nUnder);
    int wl;
    wl = wlTab[wlSel];
    expQ.push_back({1'b0, expFs(1, 0)}); tagQ.push_back({tag, " lead R1"});
    foreach (words[k])
      for (int j = 0; j < wl; j++) begin
        expQ.push_back({expBit(words[k], j), expFs(0, j)}); tagQ.push_back(tag);
      end
    for (int u = 0; u < nUnder; u++)
      for (int j = 0; j < wl; j++) begin
        expQ.push_back({1'b0, expFs(0, j)}); tagQ.push_back({tag, " underrun R10"});
      end
    @(negedge clk); txEnable = 1;
    wait (expQ.size() == 0);
    txEnable = 0;
    @(negedge clk);
  endtask

  task automatic extTick(logic fsv, output logic d);
    @(negedge clk); fsIn = fsv; bitClkIn = 1;
    @(negedge clk); d = txData;
    bitClkIn = 0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] ws[$];
    logic d;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 txData", {31'd0, txData}, 0);
    chk("R13 bitClkOut", {31'd0, bitClkOut}, 0);
    chk("R13 fsOut", {31'd0, fsOut}, 0);
    chk("R13 txDataEmpty", {31'd0, txDataEmpty}, 1);
    chk("R13 txUnderrun", {31'd0, txUnderrun}, 0);
    rstN = 1;
    @(negedge clk);

    // R1 R2 R3 R6: WL 8, msb first, msb aligned at bit 15, late one-slot sync
    cfg(0, 0, 0, 0, 0, 1, 0, 1);
    ws = '{32'h0000_A500, 32'h0000_3C00, 32'h0000_8100};
    foreach (ws[k]) writeWord(ws[k]);
    runInternal("R2 R3 wl8", ws, 0);

    // R4 R5 R6 R7: WL 24, lsb first, lsb aligned, falling launch, early word sync, inverted
    cfg(7, 1, 1, 1, 1, 0, 1, 1);
    ws = '{32'h00C3_5A91, 32'h0012_3456};
    foreach (ws[k]) writeWord(ws[k]);
    runInternal("R4 R5 R7 wl24", ws, 0);

    // R3 R7: WL 16 msb aligned at bit 31, early one-slot sync
    cfg(3, 0, 0, 0, 0, 1, 1, 1);
    ws = '{32'hBEEF_0000, 32'h1234_FFFF};
    foreach (ws[k]) writeWord(ws[k]);
    runInternal("R3 R7 wl16", ws, 0);

    // R3 R6: WL 12 lsb aligned, msb first, late word sync; WL 20 lsb first msb aligned
    cfg(2, 0, 1, 0, 0, 0, 0, 1);
    ws = '{32'hFFFF_F9A5, 32'h0000_0C3F};
    foreach (ws[k]) writeWord(ws[k]);
    runInternal("R1 R6 wl12", ws, 0);
    cfg(5, 1, 0, 0, 0, 1, 0, 1);
    ws = '{32'h9ABC_D000};
    writeWord(ws[0]);
    runInternal("R1 R2 wl20", ws, 0);

    // R8 R11: 8-deep queue, ninth write dropped
    cfg(0, 0, 1, 0, 0, 1, 0, 1);
    irqEnable = 1;
    ws = {};
    for (int k = 0; k < 8; k++) begin
      ws.push_back(32'h11 * (k + 1));
      writeWord(ws[k]);
      if (k == 6) begin
        chk("R8 room after 7", {31'd0, txDataEmpty}, 1);
        chk("R11 irq with room", {31'd0, txIrq}, 1);
      end
    end
    chk("R8 full flag", {31'd0, txDataEmpty}, 0);
    chk("R11 irq when full", {31'd0, txIrq}, 0);
    writeWord(32'h0000_00FF);
    chk("R8 still full", {31'd0, txDataEmpty}, 0);
    runInternal("R8 fifo8", ws, 1);
    chk("R8 room after drain", {31'd0, txDataEmpty}, 1);
    chk("R10 underrun set", {31'd0, txUnderrun}, 1);
    @(negedge clk);
    chk("R10 underrun sticky", {31'd0, txUnderrun}, 1);
    clearUnderrun();
    chk("R10 underrun cleared", {31'd0, txUnderrun}, 0);
    irqEnable = 0;
    @(negedge clk);
    chk("R11 irq gated", {31'd0, txIrq}, 0);

    // R9: single holding word
    cfg(0, 0, 1, 0, 0, 1, 0, 0);
    writeWord(32'h0000_00C6);
    chk("R9 held flag", {31'd0, txDataEmpty}, 0);
    writeWord(32'h0000_0033);
    ws = '{32'h0000_00C6};
    runInternal("R9 nofifo", ws, 1);
    chk("R9 room after move", {31'd0, txDataEmpty}, 1);
    clearUnderrun();

    // R12: external bit clock and late external sync
    cfg(0, 0, 1, 0, 0, 1, 0, 1);
    clkInternal = 0; fsInternal = 0;
    writeWord(32'h0000_00A5);
    @(negedge clk); txEnable = 1;
    chk("R12 clk pin enable", {31'd0, bitClkOutEn}, 0);
    chk("R12 sync pin enable", {31'd0, fsOutEn}, 0);
    for (int j = 0; j < 8; j++) begin
      extTick(j == 0, d);
      chk("R12 ext late data", {31'd0, d}, {31'd0, 1'(8'hA5 >> (7 - j))});
    end
    extTick(0, d);
    chk("R12 idle zero", {31'd0, d}, 0);
    @(negedge clk); txEnable = 0;

    // R7 R12: external early sync delays data by one edge
    cfg(0, 0, 1, 0, 0, 1, 1, 1);
    writeWord(32'h0000_003C);
    @(negedge clk); txEnable = 1;
    extTick(1, d);
    chk("R7 ext early lead", {31'd0, d}, 0);
    for (int j = 0; j < 8; j++) begin
      extTick(0, d);
      chk("R7 ext early data", {31'd0, d}, {31'd0, 1'(8'h3C >> (7 - j))});
    end
    @(negedge clk); txEnable = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule